// File: doc/BRIEF.md
# Nibble-Processor Branch Sequencer

This block owns the 12-bit fetch address of a small 4-bit accumulator processor and decides where the next fetch goes. On each executed instruction (signalled by `exec_en`) it looks at the opcode nibble of the first instruction word and either steps past the instruction, or redirects the counter for a conditional jump, a far jump, a subroutine call, a return, a jump through a register pair, or an increment-and-skip loop test. The surrounding core provides the flags the decision needs: accumulator-is-zero, carry, the external test pin, a register-pair value and the zero result of the increment.

Subroutine calls save their return point on a three-entry circular stack. A return pops that point and, during the same cycle, asks the accumulator to load the 4-bit immediate carried in the return instruction. The stack has no overflow or underflow indication: a fourth nested call overwrites the oldest entry.

Top module: `nib_branch_seq`

## Requirements
- R1: After reset `fetch_addr` is 0x000, `acc_load` is 0, and all stack entries hold 0, so a return executed straight after reset goes to 0x000.
- R2: While `exec_en` is 0, `fetch_addr` and the stack keep their values whatever the other inputs do.
- R3: An instruction that does not redirect advances `fetch_addr` by 2 when it is a two-word instruction (opcode nibble 0x1, 0x4, 0x5, 0x7, or 0x2 with bit 0 clear) and by 1 otherwise, modulo 4096.
- R4: Opcode nibble 0x1 is a conditional jump. In its low nibble, bit 2 selects "accumulator is zero", bit 1 selects "carry is 1", bit 0 selects "test pin is 0"; the selected tests are ORed, and bit 3 inverts the result.
- R5: A conditional jump whose three select bits are 0 is never taken when bit 3 is 0 and always taken when bit 3 is 1.
- R6: A taken conditional jump loads word 2 into the low 8 bits of `fetch_addr` and keeps the upper 4 bits of the address of the jump itself.
- R7: Opcode nibble 0x4 jumps to the 12-bit address formed by word-1 bits 3:0 (upper) and word 2 (lower).
- R8: Opcode nibble 0x5 pushes the address 2 past the call onto the stack and jumps like R7.
- R9: Opcode nibble 0xC pops the stack into `fetch_addr`; during that `exec_en` cycle `acc_load` is 1 and `acc_load_val` equals word-1 bits 3:0. For all other opcodes `acc_load` is 0.
- R10: Opcode nibble 0x7 jumps within the current page to word 2 when `inc_is_zero` is 0, and steps by 2 when it is 1.
- R11: Opcode nibble 0x3 with bit 0 set replaces the low 8 bits of `fetch_addr` with `pair_value`, keeping the upper 4 bits; with bit 0 clear it steps by 1.
- R12: The stack is last-in first-out with three entries addressed circularly: a fourth push overwrites the oldest entry, and pops continue around the same ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | The instruction on the word inputs executes this cycle |
| op_word1 | input | 8 | First instruction word |
| op_word2 | input | 8 | Second instruction word (address or data byte) |
| acc_is_zero | input | 1 | Accumulator equals zero |
| carry_flag | input | 1 | Carry flag |
| test_pin | input | 1 | External test input |
| pair_value | input | 8 | Contents of the addressed register pair |
| inc_is_zero | input | 1 | The incremented register became zero |
| fetch_addr | output | 12 | Address of the next instruction to fetch |
| acc_load | output | 1 | Load the return immediate into the accumulator |
| acc_load_val | output | 4 | Immediate to load into the accumulator |

## Verification
The hardest state to reach is the ring wrap of the return stack: it needs four nested calls without an intervening return, followed by more returns than the stack can hold, with each return checked against the address of the right call. A directed chain of calls to distinct pages followed by four returns gets there, and a sweep of all 256 first-word values under all eight flag combinations, mixing calls and returns freely against a circular model in the bench, visits it again from many pointer positions.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [3:0] {
    OP_COND = 4'h1,
    OP_PAIR = 4'h2,
    OP_PIND = 4'h3,
    OP_FAR  = 4'h4,
    OP_CALL = 4'h5,
    OP_LOOP = 4'h7,
    OP_RET  = 4'hC
  } opnib_e;

  typedef enum logic [2:0] {
    K_STEP,
    K_COND,
    K_FAR,
    K_CALL,
    K_LOOP,
    K_PIND,
    K_RET
  } kind_e;

  typedef struct packed {
    kind_e kind;
    logic  two_word;
    logic  push;
    logic  pop;
    logic  imm_load;
  } dec_t;

  // Instruction length in words, derived from the first word only.
  function automatic logic is_two_word(input logic [7:0] w1);
    case (w1[7:4])
      OP_COND, OP_FAR, OP_CALL, OP_LOOP: is_two_word = 1'b1;
      OP_PAIR:                           is_two_word = ~w1[0];
      default:                           is_two_word = 1'b0;
    endcase
  endfunction

  // Same-page target: keep the upper bits, replace the low byte.
  function automatic logic [11:0] page_target(input logic [11:0] cur,
                                               input logic [7:0] low);
    page_target = {cur[11:8], low};
  endfunction

endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  logic [7:0] word1,
  output dec_t       dec
);
  always_comb begin
    dec          = '0;
    dec.kind     = K_STEP;
    dec.two_word = is_two_word(word1);
    case (word1[7:4])
      OP_COND: dec.kind = K_COND;
      OP_FAR:  dec.kind = K_FAR;
      OP_CALL: begin
        dec.kind = K_CALL;
        dec.push = 1'b1;
      end
      OP_LOOP: dec.kind = K_LOOP;
      OP_PIND: if (word1[0]) dec.kind = K_PIND;
      OP_RET: begin
        dec.kind     = K_RET;
        dec.pop      = 1'b1;
        dec.imm_load = 1'b1;
      end
      default: dec.kind = K_STEP;
    endcase
  end
endmodule

// File: rtl/seq_cond.sv
module seq_cond (
  input  logic [3:0] cond,
  input  logic       acc_is_zero,
  input  logic       carry_flag,
  input  logic       test_pin,
  output logic       taken
);
  logic [2:0] hits;
  logic       any_hit;

  // bit 2: accumulator zero, bit 1: carry set, bit 0: test pin low
  assign hits    = cond[2:0] & {acc_is_zero, carry_flag, ~test_pin};
  assign any_hit = |hits;
  assign taken   = any_hit ^ cond[3];
endmodule

// File: rtl/seq_stack.sv
module seq_stack #(
  parameter int AW    = 12,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_addr,
  output logic [AW-1:0] top_addr
);
  localparam int SPW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [SPW-1:0] LAST = SPW'(DEPTH - 1);

  logic [AW-1:0]  slot [DEPTH];
  logic [SPW-1:0] sp;
  logic [SPW-1:0] sp_up;
  logic [SPW-1:0] sp_dn;

  assign sp_up    = (sp == LAST) ? '0 : sp + 1'b1;
  assign sp_dn    = (sp == '0) ? LAST : sp - 1'b1;
  assign top_addr = slot[sp_dn];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= '0;
    end else if (push) begin
      sp <= sp_up;
    end else if (pop) begin
      sp <= sp_dn;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot[g] <= '0;
      end else if (push && sp == SPW'(g)) begin
        slot[g] <= push_addr;
      end
    end
  end

  // R12: pointer stays inside the ring
  a_r12_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= LAST);

  // R12: what was just pushed is on top next cycle
  a_r12_push_top: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> top_addr == $past(push_addr));

  // R12: a single instruction never pushes and pops together
  a_r12_one_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/nib_branch_seq.sv
module nib_branch_seq
  import seq_pkg::*;
#(
  parameter int AW        = 12,
  parameter int STK_DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_en,
  input  logic [7:0]    op_word1,
  input  logic [7:0]    op_word2,
  input  logic          acc_is_zero,
  input  logic          carry_flag,
  input  logic          test_pin,
  input  logic [7:0]    pair_value,
  input  logic          inc_is_zero,
  output logic [AW-1:0] fetch_addr,
  output logic          acc_load,
  output logic [3:0]    acc_load_val
);
  localparam int PAGE_W = 8;

  dec_t          dec;
  logic          cond_taken;
  logic [AW-1:0] seq_addr;
  logic [AW-1:0] far_addr;
  logic [AW-1:0] page_w2;
  logic [AW-1:0] page_pair;
  logic [AW-1:0] stk_top;
  logic [AW-1:0] next_addr;
  logic          do_push;
  logic          do_pop;

  seq_decode u_dec (
    .word1 (op_word1),
    .dec   (dec)
  );

  seq_cond u_cond (
    .cond        (op_word1[3:0]),
    .acc_is_zero (acc_is_zero),
    .carry_flag  (carry_flag),
    .test_pin    (test_pin),
    .taken       (cond_taken)
  );

  assign do_push = exec_en & dec.push;
  assign do_pop  = exec_en & dec.pop;

  seq_stack #(.AW(AW), .DEPTH(STK_DEPTH)) u_stk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (do_push),
    .pop       (do_pop),
    .push_addr (seq_addr),
    .top_addr  (stk_top)
  );

  assign seq_addr  = fetch_addr + (dec.two_word ? AW'(2) : AW'(1));
  assign far_addr  = AW'({op_word1[3:0], op_word2});
  assign page_w2   = {fetch_addr[AW-1:PAGE_W], op_word2};
  assign page_pair = {fetch_addr[AW-1:PAGE_W], pair_value};

  always_comb begin
    case (dec.kind)
      K_COND:        next_addr = cond_taken ? page_w2 : seq_addr;
      K_FAR, K_CALL: next_addr = far_addr;
      K_LOOP:        next_addr = inc_is_zero ? seq_addr : page_w2;
      K_PIND:        next_addr = page_pair;
      K_RET:         next_addr = stk_top;
      default:       next_addr = seq_addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_addr <= '0;
    end else if (exec_en) begin
      fetch_addr <= next_addr;
    end
  end

  assign acc_load     = exec_en & dec.imm_load;
  assign acc_load_val = op_word1[3:0];

  // R2: no execution, no movement
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> $stable(fetch_addr));

  // R5: empty select field gives the inversion bit as the decision
  a_r5_empty_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (op_word1[7:4] == 4'h1 && op_word1[2:0] == 3'b000) |-> cond_taken == op_word1[3]);

  // R7: far jump lands on the assembled 12-bit address
  a_r7_far: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && op_word1[7:4] == 4'h4) |=>
      fetch_addr == $past({op_word1[3:0], op_word2}));

  // R9: a return lands on the entry that was on top of the stack
  a_r9_ret_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && op_word1[7:4] == 4'hC) |=> fetch_addr == $past(stk_top));

  // R10: loop exit steps over both words
  a_r10_loop_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && op_word1[7:4] == 4'h7 && inc_is_zero) |=>
      fetch_addr == $past(fetch_addr) + AW'(2));
endmodule

// File: tb/sim_nib_branch_seq.sv
module sim_nib_branch_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_en = 1'b0;
  logic [7:0]  op_word1 = '0;
  logic [7:0]  op_word2 = '0;
  logic        acc_is_zero = 1'b0;
  logic        carry_flag = 1'b0;
  logic        test_pin = 1'b0;
  logic [7:0]  pair_value = '0;
  logic        inc_is_zero = 1'b0;
  logic [11:0] fetch_addr;
  logic        acc_load;
  logic [3:0]  acc_load_val;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model
  logic [11:0] m_pc = '0;
  logic [11:0] m_stk [3];
  int          m_sp = 0;

  always #4 clk = ~clk;

  nib_branch_seq u0 (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en),
    .op_word1(op_word1), .op_word2(op_word2),
    .acc_is_zero(acc_is_zero), .carry_flag(carry_flag), .test_pin(test_pin),
    .pair_value(pair_value), .inc_is_zero(inc_is_zero),
    .fetch_addr(fetch_addr), .acc_load(acc_load), .acc_load_val(acc_load_val)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'h1: tag_of = "R4";
      4'h3: tag_of = "R11";
      4'h4: tag_of = "R7";
      4'h5: tag_of = "R8";
      4'h7: tag_of = "R10";
      4'hC: tag_of = "R9";
      default: tag_of = "R3";
    endcase
  endfunction

  // Executes one instruction and checks both the same-cycle and next outputs.
  task automatic run_op(input logic [7:0] w1, input logic [7:0] w2,
                        input logic [2:0] flg, input logic [7:0] pv,
                        input logic iz, input string tag);
    logic [3:0]  op;
    int          len;
    logic [11:0] stepped, exp;
    bit          any;
    @(negedge clk);
    op_word1 = w1; op_word2 = w2;
    acc_is_zero = flg[2]; carry_flag = flg[1]; test_pin = flg[0];
    pair_value = pv; inc_is_zero = iz; exec_en = 1'b1;
    op = w1[7:4];
    len = 1;
    if (op == 4'h1 || op == 4'h4 || op == 4'h5 || op == 4'h7) len = 2;
    if (op == 4'h2 && w1[0] == 1'b0) len = 2;
    stepped = 12'((32'(m_pc) + len) % 4096);
    exp = stepped;
    case (op)
      4'h1: begin
        any = (w1[2] && flg[2]) || (w1[1] && flg[1]) || (w1[0] && !flg[0]);
        if (w1[3]) any = !any;
        if (any) exp = {m_pc[11:8], w2};
      end
      4'h3: if (w1[0]) exp = {m_pc[11:8], pv};
      4'h4: exp = {w1[3:0], w2};
      4'h5: begin
        m_stk[m_sp] = stepped;
        m_sp = (m_sp + 1) % 3;
        exp = {w1[3:0], w2};
      end
      4'h7: if (!iz) exp = {m_pc[11:8], w2};
      4'hC: begin
        m_sp = (m_sp + 2) % 3;
        exp = m_stk[m_sp];
      end
      default: ;
    endcase
    #1;
    check({tag, " acc_load"}, 32'(acc_load), (op == 4'hC) ? 1 : 0);
    if (op == 4'hC) check({tag, " acc_load_val"}, 32'(acc_load_val), 32'(w1[3:0]));
    @(posedge clk);
    @(negedge clk);
    exec_en = 1'b0;
    m_pc = exp;
    check({tag, " fetch_addr"}, 32'(fetch_addr), 32'(exp));
  endtask

  task automatic go_to(input logic [11:0] a);
    run_op({4'h4, a[11:8]}, a[7:0], 3'b000, 8'h00, 1'b0, "R7");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    for (int k = 0; k < 3; k++) m_stk[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 fetch_addr", 32'(fetch_addr), 0);
    check("R1 acc_load", 32'(acc_load), 0);
    // R1: empty stack returns 0
    go_to(12'h5A0);
    run_op(8'hC7, 8'h00, 3'b000, 8'h00, 1'b0, "R1");

    // R2: idle cycles with a jump on the inputs
    go_to(12'h234);
    op_word1 = 8'h4F; op_word2 = 8'hFF; pair_value = 8'h11;
    repeat (5) @(negedge clk);
    check("R2 fetch_addr", 32'(fetch_addr), 32'h234);
    run_op(8'hC3, 8'h00, 3'b000, 8'h00, 1'b0, "R2");

    // R3: wrap at the top of the space
    go_to(12'hFFF);
    run_op(8'h00, 8'h00, 3'b000, 8'h00, 1'b0, "R3");
    go_to(12'hFFE);
    run_op(8'h7A, 8'h00, 3'b000, 8'h00, 1'b1, "R3");
    go_to(12'h3FF);
    run_op(8'h20, 8'h99, 3'b000, 8'h00, 1'b0, "R3");

    // R5: empty select field, all flag patterns
    for (int f = 0; f < 8; f++) begin
      go_to(12'h640);
      run_op(8'h10, 8'h55, 3'(f), 8'h00, 1'b0, "R5");
      go_to(12'h640);
      run_op(8'h18, 8'h55, 3'(f), 8'h00, 1'b0, "R5");
    end

    // R6: page kept from the jump address
    go_to(12'h7FE);
    run_op(8'h18, 8'h33, 3'b000, 8'h00, 1'b0, "R6");
    check("R6 page", 32'(fetch_addr), 32'h733);

    // R12: four nested calls then four returns
    go_to(12'h100);
    run_op(8'h52, 8'h00, 3'b000, 8'h00, 1'b0, "R12");
    run_op(8'h53, 8'h00, 3'b000, 8'h00, 1'b0, "R12");
    run_op(8'h54, 8'h00, 3'b000, 8'h00, 1'b0, "R12");
    run_op(8'h55, 8'h00, 3'b000, 8'h00, 1'b0, "R12");
    run_op(8'hC0, 8'h00, 3'b000, 8'h00, 1'b0, "R12");
    check("R12 first pop", 32'(fetch_addr), 32'h402);
    run_op(8'hC1, 8'h00, 3'b000, 8'h00, 1'b0, "R12");
    check("R12 second pop", 32'(fetch_addr), 32'h302);
    run_op(8'hC2, 8'h00, 3'b000, 8'h00, 1'b0, "R12");
    check("R12 third pop", 32'(fetch_addr), 32'h202);
    run_op(8'hC3, 8'h00, 3'b000, 8'h00, 1'b0, "R12");
    check("R12 wrapped pop", 32'(fetch_addr), 32'h402);

    // Sweep: every first word under every flag pattern
    for (int i = 0; i < 256; i++) begin
      for (int f = 0; f < 8; f++) begin
        run_op(8'(i), 8'(i * 7 + f * 13), 3'(f), 8'(i ^ (f * 37)), f[0],
               tag_of(4'(i >> 4)));
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule